// File: doc/BRIEF.md
# Cascaded Seven-Channel DMA Address Generator

This block keeps the address and count state of seven DMA channels. They are grouped as a lower controller (channels 0 to 3) and an upper controller (channels 5 to 7). Channel 4 is the permanent link between the two controllers and never moves data. The block does not time any bus cycle and does not move any data. It decides which channel is served next, and for each served transfer it reports a 24-bit address, whether the transfer is 8 or 16 bits wide, and whether the channel's count ran out on that transfer.

Software programs each channel through a one-cycle write port. It addresses a channel number and a field code, and it can set the base address, base count, page, mode, software request and mask of that channel. Hardware raises a request per channel on `hw_req`. Each cycle in which `xfer_strobe` is high and at least one eligible request exists, one transfer is served. The result appears on the registered outputs one clock later.

Top module: `dma_addr_gen`

## Requirements
- R1: Channel 4 is never served. Writes addressed to channel 4 (any field, including software request and mask) and `hw_req[4]` have no effect on the outputs.
- R2: A transfer is served only at a clock edge where `xfer_strobe` is 1 and some channel other than 4 has an unmasked request. Its outputs (`xfer_valid`=1, `xfer_ch`, a one-hot `xfer_ack`, `xfer_addr`, `xfer_wide`, `xfer_tc`) appear one cycle later. In every other cycle all outputs are 0.
- R3: Priority is fixed: the lowest eligible channel number wins. Channels 0 to 3 therefore outrank channels 5 to 7.
- R4: Channels 0 to 3 are 8-bit channels (`xfer_wide`=0). The address is {page[7:0], current[15:0]}, and the current address rises by 1 per transfer.
- R5: Channels 5 to 7 are 16-bit channels (`xfer_wide`=1). The address is {page[7:1], current[15:0], 0}; page bit 0 is ignored. The current word address rises by 1 per transfer.
- R6: Every transfer decrements the count. `xfer_tc` is 1 on the transfer served while the count is 0, so a programmed count N gives N+1 transfers.
- R7: On a terminal-count transfer with autoinit set, the current address and count reload from the base address and base count.
- R8: On a terminal-count transfer without autoinit, the channel's mask is set and its software request is cleared, so it is not served again until it is unmasked.
- R9: The page does not change when the current address wraps from 0xFFFF to 0x0000.
- R10: A software request bit set by a write is served exactly like a hardware request.
- R11: A write takes effect at the clock edge where `wr_en` is 1. The field codes are: 0 base address (also loads current), 1 base count (also loads count), 2 page, 3 mode (bit 0 = autoinit), 4 software request (bit 0), 5 mask (bit 0). Codes 6 and 7 do nothing. When a write and a transfer touch the same channel at the same edge, the transfer reports the old state and the written field takes the written value.
- R12: After synchronous reset all channels are masked, with no software request and autoinit off. All registers are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 3 | Channel addressed by the write |
| wr_field | input | 3 | Field code of the write |
| wr_data | input | 16 | Write data |
| hw_req | input | 8 | Hardware request per channel |
| xfer_strobe | input | 1 | Advance one transfer this cycle |
| xfer_valid | output | 1 | A transfer was served at the last edge |
| xfer_ch | output | 3 | Served channel number |
| xfer_ack | output | 8 | One-hot acknowledge of the served channel |
| xfer_addr | output | 24 | Transfer byte address |
| xfer_wide | output | 1 | 1 for a 16-bit transfer |
| xfer_tc | output | 1 | Terminal count reached on this transfer |

## Verification
A register write and a transfer can land on the same channel at the same edge. Two collisions matter most: a base-address write during that channel's transfer, and a mask or request write during its terminal count. The bench drives a base-address write to channel 6 in the same cycle that channel 6 is served. It then expects the old address on that transfer and the new address on the next one. A long random phase mixes writes, strobes and requests freely against a behavioural model that applies the transfer first and the write second, and it is compared every cycle.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // Field codes of the register write port
  typedef enum logic [2:0] {
    FLD_BASE_ADDR = 3'd0,
    FLD_BASE_CNT  = 3'd1,
    FLD_PAGE      = 3'd2,
    FLD_MODE      = 3'd3,
    FLD_SWREQ     = 3'd4,
    FLD_MASK      = 3'd5
  } fld_e;
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N = 8
) (
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IDX_W = $clog2(N);

  // lowest index wins: scan downward so the lowest request is written last
  always_comb begin
    idx = '0;
    gnt = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        gnt = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int DATA_W  = 16,
  parameter bit IS_WIDE = 1'b0,
  localparam int OUT_W  = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hw_req,
  input  logic              serve,
  output logic              pending,
  output logic [OUT_W-1:0]  addr,
  output logic              tc_now
);
  logic [ADDR_W-1:0] base_a, cur;
  logic [CNT_W-1:0]  base_c, cnt;
  logic [PAGE_W-1:0] page;
  logic              autoinit, swreq, mask;

  assign pending = (hw_req | swreq) & ~mask;
  assign tc_now  = (cnt == '0);

  generate
    if (IS_WIDE) begin : g_wide
      assign addr = {page[PAGE_W-1:1], cur, 1'b0};
    end else begin : g_narrow
      assign addr = {page, cur};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a   <= '0;
      cur      <= '0;
      base_c   <= '0;
      cnt      <= '0;
      page     <= '0;
      autoinit <= 1'b0;
      swreq    <= 1'b0;
      mask     <= 1'b1;
    end else begin
      if (serve) begin
        if (tc_now && autoinit) begin
          cur <= base_a;
          cnt <= base_c;
        end else begin
          cur <= cur + 1'b1;
          cnt <= cnt - 1'b1;
          if (tc_now) begin
            mask  <= 1'b1;
            swreq <= 1'b0;
          end
        end
      end
      // a write is applied after the advance, so the written field wins
      if (wr_en) begin
        case (wr_field)
          FLD_BASE_ADDR: begin
            base_a <= wr_data[ADDR_W-1:0];
            cur    <= wr_data[ADDR_W-1:0];
          end
          FLD_BASE_CNT: begin
            base_c <= wr_data[CNT_W-1:0];
            cnt    <= wr_data[CNT_W-1:0];
          end
          FLD_PAGE:  page     <= wr_data[PAGE_W-1:0];
          FLD_MODE:  autoinit <= wr_data[0];
          FLD_SWREQ: swreq    <= wr_data[0];
          FLD_MASK:  mask     <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (serve && !tc_now && !wr_en) |=> (cnt == $past(cnt) - 1'b1));

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (serve && tc_now && autoinit && !wr_en) |=> (cur == base_a && cnt == base_c));

  p_auto_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (serve && tc_now && !autoinit && !wr_en) |=> (mask && !swreq && !pending));

  p_page_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (serve && !wr_en) |=> $stable(page));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int NUM_CH  = 8,
  parameter int LINK_CH = 4,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int OUT_W  = PAGE_W + ADDR_W,
  localparam int DATA_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [2:0]        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              xfer_strobe,
  output logic              xfer_valid,
  output logic [CH_W-1:0]   xfer_ch,
  output logic [NUM_CH-1:0] xfer_ack,
  output logic [OUT_W-1:0]  xfer_addr,
  output logic              xfer_wide,
  output logic              xfer_tc
);
  logic [NUM_CH-1:0] pend, gnt, tc_v;
  logic [OUT_W-1:0]  ch_addr [NUM_CH];
  logic              any;
  logic [CH_W-1:0]   idx;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (i == LINK_CH) begin : g_link
        // cascade link: holds no state, never requests
        assign pend[i]    = 1'b0;
        assign tc_v[i]    = 1'b0;
        assign ch_addr[i] = '0;
      end else begin : g_data
        dma_channel #(
          .ADDR_W (ADDR_W),
          .CNT_W  (CNT_W),
          .PAGE_W (PAGE_W),
          .DATA_W (DATA_W),
          .IS_WIDE(i > LINK_CH)
        ) u_ch (
          .clk     (clk),
          .rst     (rst),
          .wr_en   (wr_en && (wr_ch == CH_W'(i))),
          .wr_field(wr_field),
          .wr_data (wr_data),
          .hw_req  (hw_req[i]),
          .serve   (xfer_strobe && gnt[i]),
          .pending (pend[i]),
          .addr    (ch_addr[i]),
          .tc_now  (tc_v[i])
        );
      end
    end
  endgenerate

  dma_prio_arb #(.N(NUM_CH)) u_arb (
    .req(pend),
    .gnt(gnt),
    .any(any),
    .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst || !(xfer_strobe && any)) begin
      xfer_valid <= 1'b0;
      xfer_ch    <= '0;
      xfer_ack   <= '0;
      xfer_addr  <= '0;
      xfer_wide  <= 1'b0;
      xfer_tc    <= 1'b0;
    end else begin
      xfer_valid <= 1'b1;
      xfer_ch    <= idx;
      xfer_ack   <= gnt;
      xfer_addr  <= ch_addr[idx];
      xfer_wide  <= (idx > CH_W'(LINK_CH));
      xfer_tc    <= tc_v[idx];
    end
  end

  p_link_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    hw_req[LINK_CH] |=> !xfer_ack[LINK_CH]);

  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> ($countones(xfer_ack) == 1 && xfer_ack[xfer_ch]));

  p_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !xfer_strobe |=> (!xfer_valid && xfer_ack == '0));

  p_wide_lsb_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_wide) |-> !xfer_addr[0]);
endmodule

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_ch = '0;
  logic [2:0]  wr_field = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  hw_req = '0;
  logic        xfer_strobe = 1'b0;
  logic        xfer_valid, xfer_wide, xfer_tc;
  logic [2:0]  xfer_ch;
  logic [7:0]  xfer_ack;
  logic [23:0] xfer_addr;

  dma_addr_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit started = 0, seen_link = 0;

  // behavioural reference state
  logic [15:0] m_ba[8], m_cur[8], m_bc[8], m_cnt[8];
  logic [7:0]  m_pg[8];
  bit          m_auto[8], m_sw[8], m_mask[8];
  bit          e_valid = 0, e_wide = 0, e_tc = 0;
  int          e_ch = 0;
  logic [7:0]  e_ack = '0;
  logic [23:0] e_addr = '0;

  always @(posedge clk) begin
    int w;
    started = 1;
    if (xfer_ack[4]) seen_link = 1;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        m_ba[i] = 0; m_cur[i] = 0; m_bc[i] = 0; m_cnt[i] = 0; m_pg[i] = 0;
        m_auto[i] = 0; m_sw[i] = 0; m_mask[i] = 1;
      end
      e_valid = 0; e_ch = 0; e_ack = 0; e_addr = 0; e_wide = 0; e_tc = 0;
    end else begin
      w = -1;
      for (int i = 0; i < 8; i++)
        if (w < 0 && i != 4 && (hw_req[i] || m_sw[i]) && !m_mask[i]) w = i;
      if (xfer_strobe && w >= 0) begin
        e_valid = 1; e_ch = w; e_ack = 8'(1 << w); e_wide = (w > 4);
        e_addr = e_wide ? {m_pg[w][7:1], m_cur[w], 1'b0} : {m_pg[w], m_cur[w]};
        e_tc = (m_cnt[w] == 0);
        if (e_tc && m_auto[w]) begin
          m_cur[w] = m_ba[w]; m_cnt[w] = m_bc[w];
        end else begin
          m_cur[w] = m_cur[w] + 1; m_cnt[w] = m_cnt[w] - 1;
          if (e_tc) begin m_mask[w] = 1; m_sw[w] = 0; end
        end
      end else begin
        e_valid = 0; e_ch = 0; e_ack = 0; e_addr = 0; e_wide = 0; e_tc = 0;
      end
      if (wr_en && wr_ch != 4) begin
        case (wr_field)
          3'd0: begin m_ba[wr_ch] = wr_data; m_cur[wr_ch] = wr_data; end
          3'd1: begin m_bc[wr_ch] = wr_data; m_cnt[wr_ch] = wr_data; end
          3'd2: m_pg[wr_ch] = wr_data[7:0];
          3'd3: m_auto[wr_ch] = wr_data[0];
          3'd4: m_sw[wr_ch] = wr_data[0];
          3'd5: m_mask[wr_ch] = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (xfer_valid !== e_valid || xfer_ch !== 3'(e_ch) || xfer_ack !== e_ack) begin
        n_bad++;
        $display("FAIL R3 grant: valid/ch/ack %0b/%0d/%h expected %0b/%0d/%h",
                 xfer_valid, xfer_ch, xfer_ack, e_valid, e_ch, e_ack);
      end else if (xfer_addr !== e_addr || xfer_wide !== e_wide) begin
        n_bad++;
        $display("FAIL %s address: addr/wide %h/%0b expected %h/%0b",
                 e_wide ? "R5" : "R4", xfer_addr, xfer_wide, e_addr, e_wide);
      end else if (xfer_tc !== e_tc) begin
        n_bad++;
        $display("FAIL R6 terminal count: %0b expected %0b", xfer_tc, e_tc);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int fld, input int data);
    wr_en = 1; wr_ch = 3'(ch); wr_field = 3'(fld); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset state, all masked
    chk("R12 valid after reset", 32'(xfer_valid), 0);
    hw_req = 8'hEF; xfer_strobe = 1;
    @(negedge clk);
    chk("R12 masked after reset", 32'(xfer_ack), 0);
    xfer_strobe = 0; hw_req = 0;
    @(negedge clk);

    // R11: program ch1 (narrow) and ch6 (wide, autoinit)
    wr(1, 0, 16'h1234); wr(1, 1, 2); wr(1, 2, 8'h56); wr(1, 5, 0);
    wr(6, 0, 16'hFFFE); wr(6, 1, 3); wr(6, 2, 8'h9B); wr(6, 3, 1); wr(6, 5, 0);
    // R1: writes to the link channel are ignored
    wr(4, 0, 16'h4444); wr(4, 1, 5); wr(4, 5, 0); wr(4, 4, 1);

    hw_req = 8'h52; xfer_strobe = 1;   // ch1, ch4, ch6
    @(negedge clk); chk("R3 ch1 wins", 32'(xfer_ch), 1);
    chk("R4 narrow addr", 32'(xfer_addr), 32'h561234);
    @(negedge clk); chk("R4 increment", 32'(xfer_addr), 32'h561235);
    @(negedge clk); chk("R6 tc after N+1", 32'(xfer_tc), 1);
    @(negedge clk); chk("R8 ch1 masked, ch6 served", 32'(xfer_ch), 6);
    chk("R5 wide addr", 32'(xfer_addr), 32'h9BFFFC);
    chk("R5 wide flag", 32'(xfer_wide), 1);
    @(negedge clk); chk("R5 wide step", 32'(xfer_addr), 32'h9BFFFE);
    @(negedge clk); chk("R9 page kept on wrap", 32'(xfer_addr), 32'h9A0000);
    @(negedge clk); chk("R6 wide tc", 32'(xfer_tc), 1);
    @(negedge clk); chk("R7 reload", 32'(xfer_addr), 32'h9BFFFC);
    xfer_strobe = 0;
    @(negedge clk); chk("R2 no strobe no transfer", 32'(xfer_valid), 0);

    // R10: software request on ch3
    hw_req = 8'h40;
    wr(3, 0, 16'h0010); wr(3, 1, 0); wr(3, 2, 8'h02); wr(3, 5, 0); wr(3, 4, 1);
    xfer_strobe = 1;
    @(negedge clk); chk("R10 sw request served", 32'(xfer_addr), 32'h020010);
    @(negedge clk); chk("R8 sw request cleared", 32'(xfer_ch), 6);
    chk("R8 ch6 addr", 32'(xfer_addr), 32'h9BFFFE);
    // R11: write to ch6 in the cycle ch6 is served
    wr_en = 1; wr_ch = 6; wr_field = 0; wr_data = 16'h1000;
    @(negedge clk); wr_en = 0;
    chk("R11 old addr on same-cycle write", 32'(xfer_addr), 32'h9A0000);
    @(negedge clk); chk("R11 written addr next", 32'(xfer_addr), 32'h9A2000);
    xfer_strobe = 0;
    @(negedge clk);

    // mixed random phase compared by the model every cycle
    for (int k = 0; k < 3000; k++) begin
      wr_en = ($urandom % 4) == 0;
      wr_ch = 3'($urandom);
      wr_field = 3'($urandom);
      wr_data = 16'($urandom % 4 == 0 ? $urandom % 3 : $urandom);
      hw_req = 8'($urandom);
      xfer_strobe = ($urandom % 3) != 0;
      @(negedge clk);
    end
    wr_en = 0; xfer_strobe = 0; hw_req = 0;
    @(negedge clk);
    chk("R1 link channel never acknowledged", 32'(seen_link), 0);
    finish_run();
  end
endmodule